// File: doc/BRIEF.md
# I2C Channel Select Switch Controller

This block is the digital core of a four-way bus switch that an I2C controller configures. It answers as a target at a seven-bit address. The upper four bits of that address are fixed by a parameter, and the lower three come from strap inputs, so eight copies can share one upstream bus. A write stores a channel mask, and each set mask bit drives one enable output for a downstream channel. A read returns that mask. The pass gates that join the buses are outside the block. The enable outputs stand in for them.

The upstream clock and data lines are sampled from a faster system clock. Data is seen as an input plus an open-drain pull-low output. The external active-low reset and the power-on reset both clear the mask and drop any transfer in progress. This lets software recover from a downstream segment that is stuck low.

Top module: `i2c_chan_switch`

## Requirements
- R1: While either the external reset (rst_n low) or the power-on reset (por high) is active, and after it ends, every bit of chan_en is 0, sda_pull is 0, and the interface waits for a START.
- R2: After a START, the first byte is seven address bits, MSB first, followed by a read/write bit (1 = read). When the address equals {4'b1110, addr_strap[2:0]}, the block acknowledges by holding sda_pull at 1 through the ninth SCL high phase.
- R3: When the address does not match, sda_pull stays 0 until the next START. Any bytes that follow leave chan_en unchanged.
- R4: In a matched write, every data byte is acknowledged. Bit n of the last complete data byte enables channel n (chan_en[n]), and any combination of the four may be set.
- R5: Data bits [7:4] of a written byte have no effect on chan_en.
- R6: A written mask appears on chan_en only after a STOP or a repeated START. Until then chan_en keeps its previous value.
- R7: In a matched read, the block returns {4'b0000, mask}, MSB first, with each bit valid while SCL is high. It releases SDA after the controller answers a byte with a NACK (SDA high).
- R8: A START or STOP in the middle of a data byte discards that partial byte. A START always returns the interface to address reception.
- R9: Asserting rst_n in the middle of a transfer clears chan_en at once. The next complete write then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | External asynchronous reset, active low |
| por | input | 1 | Power-on reset, active high |
| scl_i | input | 1 | Upstream serial clock level |
| sda_i | input | 1 | Upstream serial data level |
| addr_strap | input | 3 | Low three bits of the target address |
| sda_pull | output | 1 | 1 pulls upstream SDA low (open drain) |
| chan_en | output | 4 | Downstream channel enables, bit n = channel n |

## Verification
On every cycle, the assertions check the following. Reset holds the enables at zero. The enables move only on a commit strobe, and when they do they take the staged mask. A START always lands the machine in address reception. A STOP always frees SDA. SDA is only pulled after an address match. The bench scenarios cover the parts no assertion can reach: the value read back, the acknowledge at the bus level for matching and foreign addresses, the masking of the upper data bits, and aborted partial bytes. They also cover recovery from a reset in mid-transfer.

// File: rtl/i2csw_pkg.sv
package i2csw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } sw_state_e;

  // Address byte (7 address bits + R/W in bit 0) against the block's own address.
  function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] own);
    return rx[7:1] == own;
  endfunction

  // Returns 1 when the bus byte/ack counter says all eight bits are in.
  function automatic logic byte_full(input logic [3:0] cnt);
    return cnt == 4'd8;
  endfunction

endpackage

// File: rtl/i2csw_sync.sv
module i2csw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw;
  logic [NLINE-1:0] synced;
  logic [NLINE-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '1;
      else         chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) prev <= '1;
    else         prev <= synced;
  end

  // line 0 = SCL, line 1 = SDA
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~prev[0];
  assign scl_fall  = ~synced[0] & prev[0];
  assign start_evt = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_evt  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/i2csw_engine.sv
module i2csw_engine
  import i2csw_pkg::*;
#(
  parameter int         NCH     = 4,
  parameter int         STRAP_W = 3,
  parameter logic [6-STRAP_W:0] ADDR_HI = 4'b1110
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic [STRAP_W-1:0] strap,
  input  logic [NCH-1:0]     cur_mask,
  output logic               sda_pull,
  output logic [NCH-1:0]     pend_mask,
  output logic               commit_evt,
  output sw_state_e          state,
  output logic               addr_hit_q
);
  localparam int PAD = 8 - NCH;

  logic [6:0] own_addr;
  logic [7:0] rd_byte;
  logic [7:0] shreg;
  logic [3:0] bitcnt;
  logic       rw_q;
  logic       pend_valid;
  logic       pull_q;
  logic       acked_q;

  assign own_addr   = {ADDR_HI, strap};
  assign rd_byte    = {{PAD{1'b0}}, cur_mask};
  assign commit_evt = pend_valid & (start_evt | stop_evt);
  assign sda_pull   = pull_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bitcnt     <= '0;
      rw_q       <= 1'b0;
      pend_valid <= 1'b0;
      pend_mask  <= '0;
      pull_q     <= 1'b0;
      acked_q    <= 1'b0;
      addr_hit_q <= 1'b0;
    end else if (start_evt) begin
      state      <= ST_ADDR;
      bitcnt     <= '0;
      pull_q     <= 1'b0;
      addr_hit_q <= 1'b0;
      pend_valid <= 1'b0;
    end else if (stop_evt) begin
      state      <= ST_IDLE;
      pull_q     <= 1'b0;
      addr_hit_q <= 1'b0;
      pend_valid <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise && !byte_full(bitcnt)) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && byte_full(bitcnt)) begin
            if (addr_hit(shreg, own_addr)) begin
              addr_hit_q <= 1'b1;
              rw_q       <= shreg[0];
              pull_q     <= 1'b1;
              state      <= ST_AACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              shreg  <= rd_byte;
              pull_q <= ~rd_byte[7];
              bitcnt <= 4'd1;
              state  <= ST_RDAT;
            end else begin
              pull_q <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WDAT;
            end
          end
        end
        ST_WDAT: begin
          if (scl_rise && !byte_full(bitcnt)) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && byte_full(bitcnt)) begin
            pull_q     <= 1'b1;
            pend_mask  <= shreg[NCH-1:0];
            pend_valid <= 1'b1;
            state      <= ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            pull_q <= 1'b0;
            bitcnt <= '0;
            state  <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (byte_full(bitcnt)) begin
              pull_q <= 1'b0;
              state  <= ST_RACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              pull_q <= ~shreg[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            acked_q <= ~sda_s;
          end else if (scl_fall) begin
            if (acked_q) begin
              shreg  <= rd_byte;
              pull_q <= ~rd_byte[7];
              bitcnt <= 4'd1;
              state  <= ST_RDAT;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_chan_switch.sv
module i2c_chan_switch
  import i2csw_pkg::*;
#(
  parameter int   NCH         = 4,
  parameter int   STRAP_W     = 3,
  parameter logic [6-STRAP_W:0] ADDR_HI = 4'b1110,
  parameter int   SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               por,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] addr_strap,
  output logic               sda_pull,
  output logic [NCH-1:0]     chan_en
);
  logic      arst_n;
  logic      sda_s;
  logic      scl_rise;
  logic      scl_fall;
  logic      start_evt;
  logic      stop_evt;
  logic      commit_evt;
  logic      addr_hit_q;
  logic [NCH-1:0] pend_mask;
  logic [NCH-1:0] mask_q;
  sw_state_e eng_state;

  assign arst_n = rst_n & ~por;

  i2csw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .arst_n    (arst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2csw_engine #(.NCH(NCH), .STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) u_eng (
    .clk        (clk),
    .arst_n     (arst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .strap      (addr_strap),
    .cur_mask   (mask_q),
    .sda_pull   (sda_pull),
    .pend_mask  (pend_mask),
    .commit_evt (commit_evt),
    .state      (eng_state),
    .addr_hit_q (addr_hit_q)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)         mask_q <= '0;
    else if (commit_evt) mask_q <= pend_mask;
  end

  assign chan_en = mask_q;

endmodule

// File: rtl/i2c_chan_switch_chk.sv
module i2c_chan_switch_chk
  import i2csw_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           por,
  input logic           arst_n,
  input logic           start_evt,
  input logic           stop_evt,
  input logic           commit_evt,
  input logic           addr_hit_q,
  input logic           sda_pull,
  input logic [NCH-1:0] pend_mask,
  input logic [NCH-1:0] chan_en,
  input sw_state_e      eng_state
);

  // R1
  always @(posedge clk) begin
    if (!rst_n || por) begin
      rst_clear_chk: assert (chan_en == '0 && !sda_pull);
    end
  end

  // R6
  hold_mask_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !commit_evt |=> $stable(chan_en));

  // R4
  load_mask_chk: assert property (@(posedge clk) disable iff (!arst_n)
    commit_evt |=> chan_en == $past(pend_mask));

  // R8
  start_addr_chk: assert property (@(posedge clk) disable iff (!arst_n)
    start_evt |=> eng_state == ST_ADDR);

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    stop_evt |=> !sda_pull);

  // R3
  pull_needs_hit_chk: assert property (@(posedge clk) disable iff (!arst_n)
    sda_pull |-> addr_hit_q);

endmodule

bind i2c_chan_switch i2c_chan_switch_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .por        (por),
  .arst_n     (arst_n),
  .start_evt  (start_evt),
  .stop_evt   (stop_evt),
  .commit_evt (commit_evt),
  .addr_hit_q (addr_hit_q),
  .sda_pull   (sda_pull),
  .pend_mask  (pend_mask),
  .chan_en    (chan_en),
  .eng_state  (eng_state)
);

// File: tb/i2c_chan_switch_test.sv
module i2c_chan_switch_test;
  localparam int CLK_P = 10;
  localparam int Q     = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] OWN   = {4'b1110, STRAP};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_pull;
  logic [3:0] chan_en;

  always #(CLK_P/2) clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  i2c_chan_switch uut (
    .clk(clk), .rst_n(rst_n), .por(por), .scl_i(scl), .sda_i(sda_line),
    .addr_strap(STRAP), .sda_pull(sda_pull), .chan_en(chan_en)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int settle_until = 6;
  int exp_mask = 0;
  int byte_idx = 0;
  bit model_hit = 0;
  bit model_rw = 0;
  int pend_q[$];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Per-clock comparison of enables against the model (R6 hold, R4 load).
  always @(negedge clk) begin
    cyc++;
    if (cyc > settle_until) chk("R6 per-clock chan_en", int'(chan_en), exp_mask);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_commit();
    settle_until = cyc + 6;
    if (pend_q.size() > 0) exp_mask = pend_q[$] & 15;
    pend_q.delete();
  endtask

  task automatic bus_start();
    if (scl == 1'b0) begin
      tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    end
    model_commit();
    m_sda = 1'b0; tick(Q); scl = 1'b0;
    byte_idx = 0;
  endtask

  task automatic bus_stop();
    tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    model_commit();
    m_sda = 1'b1; tick(Q);
    model_hit = 0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      tick(Q); m_sda = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input string req);
    bit exp_ack;
    if (byte_idx == 0) begin
      model_hit = (b[7:1] == OWN);
      model_rw  = b[0];
      exp_ack   = model_hit;
    end else begin
      exp_ack = model_hit && !model_rw;
    end
    send_bits(b, 8);
    tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    chk(req, int'(sda_pull), int'(exp_ack));
    tick(Q); scl = 1'b0;
    if (exp_ack && byte_idx > 0) pend_q.push_back(int'(b));
    byte_idx++;
  endtask

  task automatic recv_byte(input bit nack, input string req);
    logic [7:0] d = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
      d = {d[6:0], sda_line}; tick(Q); scl = 1'b0;
    end
    chk(req, int'(d), exp_mask & 15);
    tick(Q); m_sda = nack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
    tick(Q);
    if (nack) chk("R7 release after NACK", int'(sda_pull), 0);
  endtask

  task automatic write_txn(input logic [7:0] a, input logic [7:0] d, input string req);
    bus_start();
    send_byte({a[6:0], 1'b0}, req);
    send_byte(d, req);
    bus_stop();
    tick(Q);
  endtask

  task automatic reset_pulse(input bit use_por);
    settle_until = cyc + 4;
    exp_mask = 0;
    pend_q.delete();
    if (use_por) por = 1'b1; else rst_n = 1'b0;
    tick(1);
    chk(use_por ? "R1 por clears" : "R9 reset clears", int'(chan_en), 0);
    chk("R1 sda released in reset", int'(sda_pull), 0);
    scl = 1'b1; m_sda = 1'b1;
    tick(3);
    if (use_por) por = 1'b0; else rst_n = 1'b1;
    tick(2*Q);
  endtask

  initial begin
    tick(5);
    chk("R1 reset chan_en", int'(chan_en), 0);
    chk("R1 reset sda_pull", int'(sda_pull), 0);
    rst_n = 1'b1;
    tick(2*Q);

    // R2 R4 R6: write own address, mask appears at STOP
    write_txn(OWN, 8'h05, "R2 R4 ack write");
    chk("R4 mask 5", int'(chan_en), 5);

    // R5 upper bits ignored, R7 readback
    write_txn(OWN, 8'hFA, "R5 write FA");
    chk("R5 mask A", int'(chan_en), 4'hA);
    bus_start();
    send_byte({OWN, 1'b1}, "R2 ack read addr");
    recv_byte(1'b0, "R7 read byte 1");
    recv_byte(1'b1, "R7 read byte 2");
    bus_stop();

    // R3 foreign address: no ack, data ignored
    write_txn(OWN ^ 7'h01, 8'h0F, "R3 no ack foreign");
    chk("R3 mask unchanged", int'(chan_en), 4'hA);

    // R6 repeated start commits before the read
    bus_start();
    send_byte({OWN, 1'b0}, "R6 addr");
    send_byte(8'h03, "R6 data");
    tick(Q);
    chk("R6 not yet applied", int'(chan_en), 4'hA);
    bus_start();
    send_byte({OWN, 1'b1}, "R6 read addr");
    recv_byte(1'b1, "R6 read after restart");
    bus_stop();
    chk("R6 mask 3", int'(chan_en), 3);

    // R8 partial byte then STOP: discarded
    bus_start();
    send_byte({OWN, 1'b0}, "R8 addr");
    send_bits(8'hCC, 4);
    bus_stop();
    chk("R8 partial+stop", int'(chan_en), 3);

    // R8 partial byte then START: new transfer works
    bus_start();
    send_byte({OWN, 1'b0}, "R8 addr 2");
    send_bits(8'h0F, 5);
    bus_start();
    send_byte({OWN, 1'b0}, "R8 addr after restart");
    send_byte(8'h0C, "R8 data after restart");
    bus_stop();
    chk("R8 mask C", int'(chan_en), 4'hC);

    // R4 combinations
    write_txn(OWN, 8'h0F, "R4 all");
    chk("R4 mask F", int'(chan_en), 4'hF);
    write_txn(OWN, 8'h08, "R4 single");
    chk("R4 mask 8", int'(chan_en), 8);
    write_txn(OWN, 8'h00, "R4 none");
    chk("R4 mask 0", int'(chan_en), 0);

    // R9 reset mid-transfer, then recovery
    write_txn(OWN, 8'h09, "R9 setup");
    bus_start();
    send_byte({OWN, 1'b0}, "R9 addr");
    send_bits(8'hFF, 3);
    reset_pulse(1'b0);
    write_txn(OWN, 8'h06, "R9 after reset");
    chk("R9 mask 6", int'(chan_en), 6);

    // R1 power-on reset
    reset_pulse(1'b1);
    chk("R1 after por", int'(chan_en), 0);
    write_txn(OWN, 8'h01, "R1 after por write");
    chk("R1 post-por write", int'(chan_en), 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule